// File: doc/BRIEF.md
# Ten-to-One Serializer with Gated Outputs

This block turns a stream of 10-bit characters into a serial bit stream. It runs on a single bit clock that is exactly ten times the character rate. An internal counter cycles through ten states, and nothing else sets the timing. Once per cycle the counter tells the shift register to take a new parallel character. In the same cycle it drives a read pulse at character rate. An upstream FIFO uses that pulse to present the next character.

The serial stream leaves the block on three outputs. Outputs A and B can be forced low by the `outOff` control at any moment, even partway through a character. This serves as a light-off hook for a laser safety controller. Output C ignores that control and always carries the stream, so a loopback path can keep watching the link.

Top module: `serTenToOne`

## Requirements
- R1: While `rstN` is low, `serOutA`, `serOutB` and `serOutC` are 0 and `readPulse` is 1 (the counter is held at count 0).
- R2: After reset is released, the outputs stay 0 for the first ten bit clock edges, whatever `parWord` holds. The first character is taken on the tenth edge, when the counter wraps from 9 to 0.
- R3: A new character is taken every ten bit clocks, on the edge where the counter leaves count 9. Its ten bits appear on the following ten bit times, with no gap between characters.
- R4: Bits leave in the order `parWord[0]` (bit a) first, then `parWord[1]`, and so on, ending with `parWord[9]`.
- R5: `parWord` is sampled only on the load edge. Changes on any other edge have no effect on the bits being sent.
- R6: `readPulse` is high for counts 0 to 4 and low for counts 5 to 9. This gives a fixed 10-cycle period, and the pulse rises on the same edge that loads a character.
- R7: `serOutC` carries the serial stream at all times, whatever `outOff` does.
- R8: While `outOff` is high, `serOutA` and `serOutB` are 0. The control passes through combinationally, with no clock, so it takes effect mid-character.
- R9: While `outOff` is low, `serOutA` and `serOutB` equal `serOutC`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bitClk | input | 1 | Bit clock, ten times the character rate |
| rstN | input | 1 | Asynchronous reset, active low |
| parWord | input | 10 | Parallel character; bit 0 is sent first |
| outOff | input | 1 | Forces serOutA and serOutB to 0, unsynchronized |
| readPulse | output | 1 | Character-rate read strobe, high for counts 0 to 4 |
| serOutA | output | 1 | Gated serial output A |
| serOutB | output | 1 | Gated serial output B |
| serOutC | output | 1 | Ungated serial output for loopback |

## Verification
Every result depends on the edge count since reset release.

- **Load and first bit:** `parWord` is taken on the 10th, 20th, ... edge. Bit j of that character is due right after the load edge plus j further edges.
- **Read pulse:** `readPulse` follows the same counter, so after edge n it is high when n mod 10 is below 5.
- **How the bench samples:** inputs change only at falling edges, and outputs are sampled there too. Each task steps one falling edge per bit, so every sample lands exactly one register stage after the edge that caused it.
- **`outOff` checks:** the gated outputs respond with no clock at all, so they are checked 1 ns after the toggle, between clock edges.

// File: rtl/ser_pkg.sv
package ser_pkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic load;      // take a new parallel character on this edge
    logic readHigh;  // read pulse level for this bit time
  } serStrobes_t;
endpackage

// File: rtl/serCtrl.sv
module serCtrl
  import ser_pkg::*;
#(
  parameter int WORD_W = 10,
  localparam int CNT_W = $clog2(WORD_W),
  localparam int HALF  = WORD_W / 2
) (
  input  logic        bitClk,
  input  logic        rstN,
  output serStrobes_t strobes
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] phaseCnt;

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN)                phaseCnt <= '0;
    else if (phaseCnt == LAST) phaseCnt <= '0;
    else                      phaseCnt <= phaseCnt + 1'b1;
  end

  always_comb begin
    strobes.load     = (phaseCnt == LAST);
    strobes.readHigh = (phaseCnt < CNT_W'(HALF));
  end

  // R3
  cnt_step_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    (phaseCnt != LAST) |=> (phaseCnt == $past(phaseCnt) + 1'b1));

  // R3
  cnt_wrap_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    strobes.load |=> (phaseCnt == '0));

  // R6
  read_fall_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    (phaseCnt == CNT_W'(HALF - 1)) |=> !strobes.readHigh);
endmodule

// File: rtl/serDatapath.sv
module serDatapath
  import ser_pkg::*;
#(
  parameter int WORD_W  = 10,
  parameter int GATED_N = 2
) (
  input  logic               bitClk,
  input  logic               rstN,
  input  serStrobes_t        strobes,
  input  logic [WORD_W-1:0]  parWord,
  input  logic               outOff,
  output logic [GATED_N-1:0] gatedOut,
  output logic               loopOut
);
  logic [WORD_W-1:0] shiftReg;
  logic              serialBit;

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strobes.load) shiftReg <= parWord;
    else                   shiftReg <= {1'b0, shiftReg[WORD_W-1:1]};
  end

  assign serialBit = shiftReg[0];
  assign loopOut   = serialBit;

  for (genvar g = 0; g < GATED_N; g++) begin : g_gate
    assign gatedOut[g] = serialBit & ~outOff;
  end

  // R4
  shift_order_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    !strobes.load |=> (serialBit == $past(shiftReg[1])));

  // R3
  load_first_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    strobes.load |=> (serialBit == $past(parWord[0])));

  // R8
  gate_off_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    outOff |-> (gatedOut == '0));
endmodule

// File: rtl/serTenToOne.sv
module serTenToOne
  import ser_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              bitClk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] parWord,
  input  logic              outOff,
  output logic              readPulse,
  output logic              serOutA,
  output logic              serOutB,
  output logic              serOutC
);
  serStrobes_t strobes;
  logic [1:0]  gatedOut;

  serCtrl #(.WORD_W(WORD_W)) u_ctrl (
    .bitClk (bitClk),
    .rstN   (rstN),
    .strobes(strobes)
  );

  serDatapath #(.WORD_W(WORD_W), .GATED_N(2)) u_dp (
    .bitClk  (bitClk),
    .rstN    (rstN),
    .strobes (strobes),
    .parWord (parWord),
    .outOff  (outOff),
    .gatedOut(gatedOut),
    .loopOut (serOutC)
  );

  assign readPulse = strobes.readHigh;
  assign serOutA   = gatedOut[0];
  assign serOutB   = gatedOut[1];

  // R6
  read_rise_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    $rose(readPulse) |-> $past(strobes.load));

  // R9
  copy_match_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    !outOff |-> (serOutA == serOutC && serOutB == serOutC));
endmodule

// File: tb/sim_serTenToOne.sv
module sim_serTenToOne;
  logic       bitClk = 1'b0;
  logic       rstN;
  logic [9:0] parWord;
  logic       outOff;
  logic       readPulse, serOutA, serOutB, serOutC;

  int checks = 0;
  int errors = 0;

  serTenToOne u0 (
    .bitClk(bitClk), .rstN(rstN), .parWord(parWord), .outOff(outOff),
    .readPulse(readPulse), .serOutA(serOutA), .serOutB(serOutB), .serOutC(serOutC)
  );

  always #10 bitClk = ~bitClk;  // 50 MHz

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkOuts(input string req, input logic a, input logic b, input logic c);
    check(serOutA === a, {req, " serOutA"}, serOutA, a);
    check(serOutB === b, {req, " serOutB"}, serOutB, b);
    check(serOutC === c, {req, " serOutC"}, serOutC, c);
  endtask

  // Send one character, starting at the falling edge where the counter is 9.
  // flipAt >= 0: parWord is inverted after bit flipAt (R5).
  // offFrom/offTo: outOff is raised after bit offFrom and dropped after bit offTo (R8).
  task automatic sendChar(input logic [9:0] word, input int flipAt,
                          input int offFrom, input int offTo);
    parWord = word;
    for (int j = 0; j < 10; j++) begin
      @(negedge bitClk);
      // R3 R4 R7 R9: bit j of the character leaves on bit time j
      checkOuts("R4", outOff ? 1'b0 : word[j], outOff ? 1'b0 : word[j], word[j]);
      // R6
      check(readPulse === (j < 5), "R6 readPulse", readPulse, j < 5);
      if (j == flipAt) parWord = ~word;
      if (j == offFrom) begin
        #2 outOff = 1'b1;
        #1;
        // R8: takes effect between edges, mid-character
        checkOuts("R8", 1'b0, 1'b0, word[j]);
      end
      if (j == offTo) begin
        #2 outOff = 1'b0;
        #1;
        // R9
        checkOuts("R9", word[j], word[j], word[j]);
      end
    end
  endtask

  task automatic testReset();
    rstN = 1'b0; parWord = '1; outOff = 1'b0;
    repeat (3) @(negedge bitClk);
    // R1
    checkOuts("R1", 1'b0, 1'b0, 1'b0);
    check(readPulse === 1'b1, "R1 readPulse", readPulse, 1);
    rstN = 1'b1;
  endtask

  task automatic testFirstWrap();
    for (int k = 1; k < 10; k++) begin
      @(negedge bitClk);
      // R2: nothing loaded before the first wrap
      checkOuts("R2", 1'b0, 1'b0, 1'b0);
      check(readPulse === (k < 5), "R6 readPulse before wrap", readPulse, k < 5);
    end
  endtask

  task automatic testStream();
    sendChar(10'b1010110001, -1, -1, -1);  // R3 R4
    sendChar(10'b0000000001, -1, -1, -1);
    sendChar(10'b1000000000, -1, -1, -1);
    sendChar(10'b1111111111, -1, -1, -1);
    sendChar(10'b0011111010, -1, -1, -1);
  endtask

  task automatic testIgnoreInput();
    sendChar(10'b0110010111, 2, -1, -1);   // R5
    sendChar(10'b1100110011, 8, -1, -1);   // R5
  endtask

  task automatic testOutputOff();
    sendChar(10'b1111111111, -1, 3, 6);    // R8 R7 R9
    sendChar(10'b1011011101, -1, 0, 9);
  endtask

  initial begin
    testReset();
    testFirstWrap();
    testStream();
    testIgnoreInput();
    testOutputOff();
    sendChar(10'b0101010101, -1, -1, -1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule